// File: doc/BRIEF.md
# Selectable DSP Sample Strobe Generator

This block issues the one-cycle start-of-sample pulse that launches each processing pass of a DSP core. Its time base is a single-cycle tick at twice the nominal base rate, for example 96 kHz against a 48 kHz base. A 4-bit rate selection value picks the pulse rate. Seven codes divide the double-rate tick by a fixed integer, giving rates of 2x, 1x, 1/1.5, 1/2, 1/3, 1/4 and 1/6 of the base rate. Two codes slave the pulse to the frame strobe of the serial input port or of the serial output port. All remaining codes stop the pulse.

The selection value is compared with its value from the previous clock. When it changes, the divide counter restarts, so the first pulse at the new rate comes on the next tick. The block does not generate the tick itself and contains no serial port logic. The selection reset value is code 0001, which gives the base rate.

Top module: `dsp_sample_strobe_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `smp_strobe` is low.
- R2: With `rate_sel` = 4'b0000, every tick produces a strobe.
- R3: With `rate_sel` = 4'b0001, a strobe comes on every 2nd tick.
- R4: With `rate_sel` = 4'b0010, a strobe comes on every 3rd tick. With 4'b0011, a strobe comes on every 4th tick.
- R5: A strobe comes on every 6th tick with `rate_sel` = 4'b0100, on every 8th tick with 4'b0101, and on every 12th tick with 4'b0110.
- R6: In the divide codes (4'b0000 to 4'b0110), `smp_strobe` is high only in the clock cycle that follows a cycle with `base2x_tick` high. In that mode it never rises without a tick.
- R7: With `rate_sel` = 4'b0111, each rising edge of `sin_frame` gives exactly one strobe, in the cycle after the edge is first seen high. `sout_frame` is ignored in this mode.
- R8: With `rate_sel` = 4'b1000, each rising edge of `sout_frame` gives exactly one strobe, one cycle later. `sin_frame` is ignored in this mode.
- R9: Codes 4'b1111 and 4'b1001 to 4'b1110 never produce a strobe, whatever the tick and frame inputs do.
- R10: In the cycle where `rate_sel` differs from its value on the previous clock, no strobe is generated. The divide count restarts, so the first tick after the change produces a strobe.
- R11: After reset the divide count starts at zero, so the first tick under a divide code produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base2x_tick | input | 1 | One-cycle tick at twice the base sample rate |
| sin_frame | input | 1 | Serial input port frame strobe |
| sout_frame | input | 1 | Serial output port frame strobe |
| rate_sel | input | 4 | Rate selection code |
| smp_strobe | output | 1 | One-cycle sample start strobe |

## Verification
The hardest situation to reach is a selection change that lands partway through a long divide period. Only then does the restart behaviour differ from letting the counter run on. The stimulus handles this by leaving code 4'b0110 after a few ticks and moving to a new divide code. It then expects a strobe on the very next tick, followed by the new period. The follow modes get frame pulses several cycles wide, while the other frame input and the tick toggle. This shows that only the rising edge of the selected frame input counts.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int SEL_W = 4;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    MODE_DIV  = 2'd0,
    MODE_SIN  = 2'd1,
    MODE_SOUT = 2'd2,
    MODE_OFF  = 2'd3
  } strobe_mode_e;

  // Tick count per strobe for each divide code; 0 for codes that do not divide.
  function automatic logic [CNT_W-1:0] div_of(input logic [SEL_W-1:0] code);
    case (code)
      4'd0:    div_of = 4'd1;
      4'd1:    div_of = 4'd2;
      4'd2:    div_of = 4'd3;
      4'd3:    div_of = 4'd4;
      4'd4:    div_of = 4'd6;
      4'd5:    div_of = 4'd8;
      4'd6:    div_of = 4'd12;
      default: div_of = '0;
    endcase
  endfunction

  function automatic strobe_mode_e mode_of(input logic [SEL_W-1:0] code);
    if (code <= 4'd6)       mode_of = MODE_DIV;
    else if (code == 4'd7)  mode_of = MODE_SIN;
    else if (code == 4'd8)  mode_of = MODE_SOUT;
    else                    mode_of = MODE_OFF;
  endfunction
endpackage

// File: rtl/sel_decode.sv
module sel_decode
  import strobe_pkg::*;
(
  input  logic [SEL_W-1:0] code,
  output strobe_mode_e     mode,
  output logic [CNT_W-1:0] divisor
);
  always_comb begin
    mode    = mode_of(code);
    divisor = div_of(code);
  end

  // R5: every divide code yields a divisor in 1..12
  always_comb begin
    if (mode == MODE_DIV)
      p_divisor_range_r5: assert (divisor >= 4'd1 && divisor <= 4'd12)
        else $error("divisor out of range");
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] divisor,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;

  assign fire = enable && tick && !restart && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (enable && tick)
      cnt <= (cnt == '0) ? divisor - 4'd1 : cnt - 4'd1;
  end

  // R5: the remaining count stays below the selected divisor
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !restart) |=> (cnt < $past(divisor) || $past(divisor) == '0))
    else $error("divide count exceeds divisor");

  // R10: a restart clears the count
  p_restart_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0))
    else $error("count not cleared on restart");
endmodule

// File: rtl/edge_follow.sv
module edge_follow (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  output logic rise
);
  logic frame_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_d <= 1'b0;
    else        frame_d <= frame;
  end

  assign rise = frame && !frame_d;

  // R7: two consecutive cycles never both report a rising edge
  p_single_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise)
    else $error("rise reported twice");
endmodule

// File: rtl/dsp_sample_strobe_gen.sv
module dsp_sample_strobe_gen
  import strobe_pkg::*;
#(
  parameter logic [3:0] DEF_SEL = 4'b0001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base2x_tick,
  input  logic       sin_frame,
  input  logic       sout_frame,
  input  logic [3:0] rate_sel,
  output logic       smp_strobe
);
  localparam int N_FRAME = 2;

  strobe_mode_e     mode;
  logic [CNT_W-1:0] divisor;
  logic [SEL_W-1:0] sel_q;
  logic             sel_chg;
  logic             div_fire;
  logic [N_FRAME-1:0] frame_in;
  logic [N_FRAME-1:0] frame_rise;
  logic             follow_fire;
  logic             strobe_d;
  logic             strobe_q;

  sel_decode u_dec (
    .code    (rate_sel),
    .mode    (mode),
    .divisor (divisor)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= DEF_SEL;
    else        sel_q <= rate_sel;
  end

  assign sel_chg = (rate_sel != sel_q);

  tick_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (base2x_tick),
    .enable  (mode == MODE_DIV),
    .restart (sel_chg),
    .divisor (divisor),
    .fire    (div_fire)
  );

  assign frame_in = {sout_frame, sin_frame};

  for (genvar g = 0; g < N_FRAME; g++) begin : g_follow
    edge_follow u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .frame (frame_in[g]),
      .rise  (frame_rise[g])
    );
  end

  always_comb begin
    case (mode)
      MODE_SIN:  follow_fire = frame_rise[0];
      MODE_SOUT: follow_fire = frame_rise[1];
      default:   follow_fire = 1'b0;
    endcase
  end

  assign strobe_d = !sel_chg && (div_fire || follow_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign smp_strobe = strobe_q;

  // R1: strobe held low in reset
  always_ff @(posedge clk) begin
    if (!rst_n)
      p_reset_quiet_r1: assert (!smp_strobe) else $error("strobe during reset");
  end

  // R6: in divide mode no strobe without a tick
  p_div_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DIV && !base2x_tick) |=> !smp_strobe)
    else $error("strobe without tick");

  // R9: disabled codes stay silent
  p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> !smp_strobe)
    else $error("strobe in disabled mode");

  // R10: no strobe after a selection change
  p_change_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> !smp_strobe)
    else $error("strobe on selection change");

  // R7: serial input rising edge gives a strobe next cycle
  p_follow_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SIN && !sel_chg && frame_rise[0]) |=> smp_strobe)
    else $error("missed input-frame strobe");

  // R8: serial output rising edge gives a strobe next cycle
  p_follow_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOUT && !sel_chg && frame_rise[1]) |=> smp_strobe)
    else $error("missed output-frame strobe");
endmodule

// File: tb/dsp_sample_strobe_gen_test.sv
module dsp_sample_strobe_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base2x_tick = 1'b0;
  logic       sin_frame = 1'b0;
  logic       sout_frame = 1'b0;
  logic [3:0] rate_sel = 4'b0001;
  logic       smp_strobe;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  // bench model state
  logic [3:0] m_sel;
  int         m_nticks;
  logic       m_sin_prev, m_sout_prev;
  bit         m_first;

  always #5 clk = ~clk;

  dsp_sample_strobe_gen uut (
    .clk, .rst_n, .base2x_tick, .sin_frame, .sout_frame, .rate_sel, .smp_strobe
  );

  // ticks per strobe from the rate in kHz against a 96 kHz tick
  function automatic int ticks_per(input logic [3:0] s);
    int khz;
    case (s)
      4'd0: khz = 96; 4'd1: khz = 48; 4'd2: khz = 32; 4'd3: khz = 24;
      4'd4: khz = 16; 4'd5: khz = 12; 4'd6: khz = 8;
      default: khz = 0;
    endcase
    return (khz == 0) ? 0 : 96 / khz;
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic tk, input logic si, input logic so, input logic [3:0] s);
    item_t it;
    int d;
    @(negedge clk);
    base2x_tick = tk; sin_frame = si; sout_frame = so; rate_sel = s;
    d = ticks_per(s);
    it.tag = tag_of(s);
    it.exp = 1'b0;
    if (s != m_sel) begin
      it.tag = "R10";
      m_nticks = 0;
    end else if (d != 0) begin
      if (tk) begin
        it.exp = (m_nticks % d) == 0;
        if (m_first) it.tag = "R11";
        m_first = 1'b0;
        m_nticks++;
      end else begin
        it.tag = "R6";
      end
    end else if (s == 4'd7) begin
      it.exp = si && !m_sin_prev;
    end else if (s == 4'd8) begin
      it.exp = so && !m_sout_prev;
    end
    m_sin_prev = si; m_sout_prev = so; m_sel = s;
    sb.push_back(it);
  endtask

  // monitor: compare one scoreboard item per clock, after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (smp_strobe !== it.exp) begin
        n_fail++;
        $display("FAIL %s: smp_strobe=%0b expected %0b at %0t", it.tag, smp_strobe, it.exp, $time);
      end
    end
  end

  task automatic run_div(input logic [3:0] s, input int nticks, input int gap);
    for (int i = 0; i < nticks; i++) begin
      step(1'b1, 1'b0, 1'b0, s);
      for (int j = 0; j < gap; j++) step(1'b0, 1'b0, 1'b0, s);
    end
  endtask

  task automatic pulse_frame(input logic [3:0] s, input bit use_in, input int width, input int low);
    for (int i = 0; i < width; i++) step(i[0], use_in, !use_in ^ 1'b0 ? 1'b1 : 1'b0, s);
    for (int i = 0; i < low; i++) step(i[0], ~use_in & i[0], use_in & i[0], s);
  endtask

  initial begin
    m_sel = 4'b0001; m_nticks = 0; m_sin_prev = 1'b0; m_sout_prev = 1'b0; m_first = 1'b1;
    // R1: strobe low during reset while inputs toggle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      base2x_tick = i[0]; sin_frame = 1'b1;
      n_checks++;
      if (smp_strobe !== 1'b0) begin
        n_fail++;
        $display("FAIL R1: smp_strobe=%0b expected 0 in reset", smp_strobe);
      end
    end
    @(negedge clk);
    base2x_tick = 1'b0; sin_frame = 1'b0;
    rst_n = 1'b1;
    // R1: first cycle after release
    step(1'b0, 1'b0, 1'b0, 4'b0001);
    // R11, R3: default rate
    run_div(4'b0001, 10, 2);
    // R2
    run_div(4'b0000, 8, 1);
    run_div(4'b0000, 4, 0);
    // R4
    run_div(4'b0010, 9, 2);
    run_div(4'b0011, 12, 1);
    // R5
    run_div(4'b0100, 13, 1);
    run_div(4'b0101, 17, 0);
    run_div(4'b0110, 5, 3);
    // R10: change mid-period; first tick after it must strobe
    run_div(4'b0011, 9, 1);
    run_div(4'b0110, 25, 1);
    // R7: wide input frame pulses; output frame toggles
    for (int k = 0; k < 4; k++) pulse_frame(4'b0111, 1'b1, 3 + k, 4);
    // R8: wide output frame pulses; input frame toggles
    for (int k = 0; k < 4; k++) pulse_frame(4'b1000, 1'b0, 2 + k, 3);
    // R9: disabled codes with everything toggling
    for (int c = 9; c <= 15; c++)
      for (int i = 0; i < 6; i++) step(i[0], i[1], ~i[1], c[3:0]);
    // back to a divide code after disabled mode (R10)
    run_div(4'b0001, 6, 1);
    repeat (3) step(1'b0, 1'b0, 1'b0, 4'b0001);
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule